// File: doc/BRIEF.md
# Two-Channel Flow Abort and End-of-Flow Interrupt Controller

This block tracks two independent byte-streaming channels whose traffic is grouped into fixed-size packets. Each channel is started with a byte count. A byte-done strobe from the data path advances it, and it goes idle when the count runs out. Software or a control agent can cut a running flow short in one of two ways. The stop-at-byte mode ends the flow after the byte currently moving. The stop-at-packet mode lets the rest of the current packet drain first. Either way the channel's busy output stays high until the chosen boundary is reached.

Each completion or abort raises a sticky end-of-flow flag for that channel. The one exception is an abort requested while a flow descriptor is being written: that abort still stops the channel, but it raises no flag. Each flag has its own interrupt enable, and one outside global enable gates both. The interrupt line is the OR of the enabled flags under that gate. A small two-address register port gives software read access to flags and busy bits. Through the same port software writes the enables and the write-one acknowledges that clear flags. Software has no path that sets a flag.

Top module: `flow_abort_irq`

## Requirements
- R1: A flow started with length L (L >= 1) ends on the L-th byte-done strobe. At the clock edge that samples that strobe, busy falls and the channel's flag sets.
- R2: In stop-at-byte mode (abort with `abort_delayed`=0), the first byte-done strobe after the abort is taken ends the flow and sets the flag. A strobe in the same cycle as the abort counts as a byte sent before the abort.
- R3: In stop-at-packet mode (`abort_delayed`=1), the channel keeps running until a strobe completes the byte at packet position PKT_LEN-1, or the flow's last byte, whichever comes first. The position restarts at 0 at each flow start and wraps after PKT_LEN-1.
- R4: Busy only falls on a byte-done strobe. While stopping, it stays high through any number of cycles without a strobe.
- R5: An abort taken while that channel's `desc_wr` is high stops the channel at its boundary without setting the flag, unless that boundary is also the flow's last byte.
- R6: An abort on an idle channel is ignored. A second abort on a channel that is already stopping is ignored, and the first mode governs.
- R7: Writing control (address 1) with bit 1 set clears flag 0, and with bit 5 set clears flag 1. These acknowledge bits read back as 0. A set event in the same cycle as an acknowledge leaves the flag set.
- R8: Writes to status (address 0) change nothing. No write to any address can set a flag.
- R9: `irq` is high exactly when `irq_glb_en` is high and at least one channel has both its flag and its enable set.
- R10: Status (address 0) reads busy0 at bit 0, flag0 at bit 1, busy1 at bit 4 and flag1 at bit 5. Control (address 1) reads enable0 at bit 2 and enable1 at bit 6. All other bits read 0. Enables are written through the same bit positions.
- R11: A synchronous active-high reset leaves both channels idle and clears flags, enables and `irq`.
- R12: A start pulse is ignored while the channel is busy, and also when its length is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flow_start | input | 2 | Per-channel start pulse |
| flow_len | input | 2x LEN_W | Per-channel flow length in bytes, sampled at start |
| byte_done | input | 2 | Per-channel byte-completed strobe from the data path |
| abort_req | input | 2 | Per-channel abort request |
| abort_delayed | input | 2 | Abort mode: 0 stop after byte, 1 stop after packet |
| desc_wr | input | 2 | Per-channel descriptor-write-in-progress level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 status, 1 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| irq_glb_en | input | 1 | Global interrupt enable |
| chan_busy | output | 2 | Per-channel busy |
| irq | output | 1 | Interrupt request |

## Verification
The in-line assertions check the local rules every cycle. They check that an idle channel stays idle without a start, that busy never drops without a strobe, and that a stop-at-byte stop completes on the next strobe. They also check that a stop-at-packet stop survives strobes short of the boundary, that set wins over acknowledge and an acknowledge alone clears, that a flag never rises without a set event, and that the global gate holds `irq` low. Other behaviours need whole scenarios, and only the bench sequences show them. These are the exact strobe on which a flow or an abort ends relative to packet position, the silent stop under descriptor writes, the register bit layout, and start pulses ignored while busy. The bench checks them with directed cases and with a seeded random run against its own per-channel model.

// File: rtl/flow_abort_pkg.sv
package flow_abort_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {
    CH_IDLE      = 2'd0,
    CH_RUN       = 2'd1,
    CH_STOP_BYTE = 2'd2,
    CH_STOP_PKT  = 2'd3
  } ch_state_e;

  // register bit positions, channel c uses a nibble at 4*c
  function automatic int busy_bit(input int c);
    return 4 * c;
  endfunction

  function automatic int flag_bit(input int c);
    return 4 * c + 1;
  endfunction

  function automatic int ack_bit(input int c);
    return 4 * c + 1;
  endfunction

  function automatic int en_bit(input int c);
    return 4 * c + 2;
  endfunction

  // packet position arithmetic
  function automatic logic at_pkt_end(input int unsigned pos, input int unsigned pkt_len);
    return pos == pkt_len - 1;
  endfunction

  function automatic int unsigned pkt_advance(input int unsigned pos, input int unsigned pkt_len);
    return (pos == pkt_len - 1) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/flow_chan_seq.sv
module flow_chan_seq
  import flow_abort_pkg::*;
#(
  parameter int PKT_LEN = 4,
  parameter int LEN_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             byte_done,
  input  logic             abort_req,
  input  logic             abort_delayed,
  input  logic             desc_wr,
  output logic             busy,
  output logic             eof_set,
  output logic             abort_taken
);

  localparam int PKT_W = (PKT_LEN > 1) ? $clog2(PKT_LEN) : 1;

  ch_state_e        st_q;
  logic [LEN_W-1:0] rem_q;
  logic [PKT_W-1:0] pos_q;
  logic             silent_q;

  logic running, last_byte, pkt_end, finish, start_ok;

  always_comb begin
    running     = (st_q != CH_IDLE);
    last_byte   = (rem_q == LEN_W'(1));
    pkt_end     = at_pkt_end(32'(pos_q), PKT_LEN);
    finish      = running && byte_done &&
                  (last_byte || st_q == CH_STOP_BYTE || (st_q == CH_STOP_PKT && pkt_end));
    eof_set     = finish && (last_byte || !silent_q);
    abort_taken = (st_q == CH_RUN) && abort_req && !finish;
    start_ok    = (st_q == CH_IDLE) && start && (len != '0);
  end

  assign busy = running;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= CH_IDLE;
      rem_q    <= '0;
      pos_q    <= '0;
      silent_q <= 1'b0;
    end else if (start_ok) begin
      st_q     <= CH_RUN;
      rem_q    <= len;
      pos_q    <= '0;
      silent_q <= 1'b0;
    end else if (running) begin
      if (byte_done) begin
        rem_q <= rem_q - LEN_W'(1);
        pos_q <= PKT_W'(pkt_advance(32'(pos_q), PKT_LEN));
      end
      if (finish) begin
        st_q <= CH_IDLE;
      end else if (abort_taken) begin
        st_q     <= abort_delayed ? CH_STOP_PKT : CH_STOP_BYTE;
        silent_q <= desc_wr;
      end
    end
  end

  // R6: an idle channel without a start stays idle whatever abort does
  assert_idle_stays_R6: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);

  // R4: busy can only fall on a byte strobe
  assert_busy_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !byte_done) |=> busy);

  // R2: stop-at-byte completes on the next strobe
  assert_stop_byte_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == CH_STOP_BYTE && byte_done) |=> !busy);

  // R3: stop-at-packet survives strobes short of the packet boundary
  assert_stop_pkt_R3: assert property (@(posedge clk) disable iff (rst)
    (st_q == CH_STOP_PKT && byte_done && !pkt_end && !last_byte) |=> busy);

endmodule

// File: rtl/flow_eof_flag.sv
module flow_eof_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic ack,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= set | (flag & ~ack);
  end

  // R7: set wins over a simultaneous acknowledge
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);

  // R7: acknowledge alone clears
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (ack && !set) |=> !flag);

  // R8: the flag never rises without a hardware set event
  assert_rise_needs_set_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(set));

endmodule

// File: rtl/flow_irq_merge.sv
module flow_irq_merge #(
  parameter int N = 2
) (
  input  logic [N-1:0] flags,
  input  logic [N-1:0] enables,
  input  logic         glb_en,
  output logic         irq
);

  assign irq = glb_en & (|(flags & enables));

endmodule

// File: rtl/flow_abort_irq.sv
module flow_abort_irq
  import flow_abort_pkg::*;
#(
  parameter int PKT_LEN = 4,
  parameter int LEN_W   = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              flow_start,
  input  logic [1:0][LEN_W-1:0]   flow_len,
  input  logic [1:0]              byte_done,
  input  logic [1:0]              abort_req,
  input  logic [1:0]              abort_delayed,
  input  logic [1:0]              desc_wr,
  input  logic                    reg_we,
  input  logic                    reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [7:0]              reg_rdata,
  input  logic                    irq_glb_en,
  output logic [1:0]              chan_busy,
  output logic                    irq
);

  logic [NUM_CH-1:0] eof_set, abort_taken, ack, flag_q, en_q;
  logic              ctrl_wr;
  logic              wdata_unused;

  assign ctrl_wr      = reg_we && (reg_addr == 1'b1);
  assign wdata_unused = ^{reg_wdata[0], reg_wdata[3], reg_wdata[4], reg_wdata[7], abort_taken};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    flow_chan_seq #(.PKT_LEN(PKT_LEN), .LEN_W(LEN_W)) u_seq (
      .clk          (clk),
      .rst          (rst),
      .start        (flow_start[c]),
      .len          (flow_len[c]),
      .byte_done    (byte_done[c]),
      .abort_req    (abort_req[c]),
      .abort_delayed(abort_delayed[c]),
      .desc_wr      (desc_wr[c]),
      .busy         (chan_busy[c]),
      .eof_set      (eof_set[c]),
      .abort_taken  (abort_taken[c])
    );

    assign ack[c] = ctrl_wr && reg_wdata[ack_bit(c)];

    flow_eof_flag u_flag (
      .clk (clk),
      .rst (rst),
      .set (eof_set[c]),
      .ack (ack[c]),
      .flag(flag_q[c])
    );

    always_ff @(posedge clk) begin
      if (rst)          en_q[c] <= 1'b0;
      else if (ctrl_wr) en_q[c] <= reg_wdata[en_bit(c)];
    end
  end

  flow_irq_merge #(.N(NUM_CH)) u_irq (
    .flags  (flag_q),
    .enables(en_q),
    .glb_en (irq_glb_en),
    .irq    (irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr == 1'b0) begin
        reg_rdata[busy_bit(c)] = chan_busy[c];
        reg_rdata[flag_bit(c)] = flag_q[c];
      end else begin
        reg_rdata[en_bit(c)] = en_q[c];
      end
    end
  end

  // R9: the global enable gates the interrupt
  assert_glb_gate_R9: assert property (@(posedge clk) disable iff (rst)
    !irq_glb_en |-> !irq);

  // R9: an interrupt always has a pending flag behind it
  assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag_q != '0));

endmodule

// File: tb/tb_flow_abort_irq.sv
module tb_flow_abort_irq;

  localparam int PKT = 4;
  localparam int LW  = 8;

  logic           clk = 1'b0;
  logic           rst;
  logic [1:0]     flow_start, byte_done, abort_req, abort_delayed, desc_wr;
  logic [1:0][LW-1:0] flow_len;
  logic           reg_we, reg_addr, irq_glb_en;
  logic [7:0]     reg_wdata, reg_rdata;
  logic [1:0]     chan_busy;
  logic           irq;

  always #5 clk = ~clk;

  flow_abort_irq #(.PKT_LEN(PKT), .LEN_W(LW)) dut (
    .clk(clk), .rst(rst), .flow_start(flow_start), .flow_len(flow_len),
    .byte_done(byte_done), .abort_req(abort_req), .abort_delayed(abort_delayed),
    .desc_wr(desc_wr), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_glb_en(irq_glb_en), .chan_busy(chan_busy), .irq(irq)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  // model: 0 idle, 1 run, 2 stop after byte, 3 stop after packet
  int m_st[2], m_rem[2], m_pos[2];
  bit m_sil[2], m_flag[2], m_en[2];

  function automatic logic [7:0] exp_status();
    return {2'b00, m_flag[1], m_st[1] != 0, 2'b00, m_flag[0], m_st[0] != 0};
  endfunction

  function automatic logic [7:0] exp_control();
    return {1'b0, m_en[1], 3'b000, m_en[0], 2'b00};
  endfunction

  function automatic logic exp_irq();
    return irq_glb_en && ((m_flag[0] && m_en[0]) || (m_flag[1] && m_en[1]));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_st[c] = 0; m_rem[c] = 0; m_pos[c] = 0;
      m_sil[c] = 0; m_flag[c] = 0; m_en[c] = 0;
    end
  endtask

  task automatic idle_inputs();
    flow_start = '0; byte_done = '0; abort_req = '0; abort_delayed = '0;
    desc_wr = '0; reg_we = 0; reg_wdata = '0;
  endtask

  // advance model one cycle from current inputs, clock, compare
  task automatic tick();
    bit set_c, ack_c, fin, last, pend;
    for (int c = 0; c < 2; c++) begin
      set_c = 0;
      if (m_st[c] == 0) begin
        if (flow_start[c] && flow_len[c] != 0) begin
          m_st[c] = 1; m_rem[c] = flow_len[c]; m_pos[c] = 0; m_sil[c] = 0;
        end
      end else begin
        fin = 0;
        if (byte_done[c]) begin
          last = (m_rem[c] == 1);
          pend = (m_pos[c] == PKT - 1);
          fin  = last || m_st[c] == 2 || (m_st[c] == 3 && pend);
          set_c = fin && (last || !m_sil[c]);
          m_rem[c] = m_rem[c] - 1;
          m_pos[c] = pend ? 0 : m_pos[c] + 1;
          if (fin) m_st[c] = 0;
        end
        if (!fin && m_st[c] == 1 && abort_req[c]) begin
          m_st[c] = abort_delayed[c] ? 3 : 2;
          m_sil[c] = desc_wr[c];
        end
      end
      ack_c = reg_we && reg_addr && reg_wdata[4*c+1];
      m_flag[c] = set_c || (m_flag[c] && !ack_c);
      if (reg_we && reg_addr) m_en[c] = reg_wdata[4*c+2];
    end
    @(posedge clk);
    #1;
    for (int c = 0; c < 2; c++)
      check(chan_busy[c] == (m_st[c] != 0), "R4 busy vs model", chan_busy[c], m_st[c] != 0);
    check(irq == exp_irq(), "R9 irq vs model", irq, exp_irq());
    if (reg_addr == 0)
      check(reg_rdata == exp_status(), "R10 status vs model", reg_rdata, exp_status());
    else
      check(reg_rdata == exp_control(), "R10 control vs model", reg_rdata, exp_control());
  endtask

  task automatic ctrl_write(input logic [7:0] d);
    reg_we = 1; reg_addr = 1; reg_wdata = d;
    tick();
    reg_we = 0; reg_wdata = '0;
  endtask

  task automatic start_ch(input int c, input int len);
    flow_start[c] = 1; flow_len[c] = LW'(len);
    tick();
    flow_start[c] = 0;
  endtask

  task automatic strobe(input int c);
    byte_done[c] = 1;
    tick();
    byte_done[c] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    idle_inputs();
    flow_len = '0; reg_addr = 0; irq_glb_en = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    #1; rst = 0;
    model_reset();

    // R11 reset state
    check(reg_rdata == 8'h00 && chan_busy == 2'b00 && irq == 0, "R11 reset status", reg_rdata, 0);
    reg_addr = 1; #1;
    check(reg_rdata == 8'h00, "R11 reset control", reg_rdata, 0);

    // R1 normal completion with enable, R9 interrupt
    irq_glb_en = 1;
    ctrl_write(8'h44);
    reg_addr = 0;
    start_ch(0, 3);
    strobe(0); strobe(0);
    check(chan_busy[0] == 1, "R1 busy before last byte", chan_busy[0], 1);
    strobe(0);
    check(chan_busy[0] == 0 && reg_rdata[1] == 1, "R1 end of flow flag", reg_rdata, 8'h02);
    check(irq == 1, "R9 irq from flag0", irq, 1);
    irq_glb_en = 0; #1;
    check(irq == 0, "R9 global gate", irq, 0);
    irq_glb_en = 1;
    ctrl_write(8'h46);          // ack0, keep enables
    reg_addr = 0; #1;
    check(reg_rdata[1] == 0 && irq == 0, "R7 ack clears flag0", reg_rdata, 0);

    // R2 stop-at-byte with idle cycles in between
    start_ch(1, 10);
    strobe(1); strobe(1);
    abort_req[1] = 1; abort_delayed[1] = 0;
    tick();
    abort_req[1] = 0;
    repeat (3) tick();
    check(chan_busy[1] == 1, "R4 busy held while stopping", chan_busy[1], 1);
    strobe(1);
    check(chan_busy[1] == 0 && reg_rdata[5] == 1, "R2 stop after byte", reg_rdata, 8'h20);
    ctrl_write(8'h66);
    reg_addr = 0;

    // R3 stop-at-packet: abort at position 1, needs 3 more strobes
    start_ch(0, 20);
    strobe(0);
    abort_req[0] = 1; abort_delayed[0] = 1;
    tick();
    abort_req[0] = 0;
    strobe(0); strobe(0);
    check(chan_busy[0] == 1 && reg_rdata[1] == 0, "R3 still draining packet", reg_rdata, 8'h01);
    // R6 second abort while stopping is ignored (byte mode would stop now)
    abort_req[0] = 1; abort_delayed[0] = 0;
    tick();
    abort_req[0] = 0;
    strobe(0);
    check(chan_busy[0] == 0 && reg_rdata[1] == 1, "R3 stop at packet end", reg_rdata, 8'h02);
    ctrl_write(8'h46);
    reg_addr = 0;

    // R5 abort under descriptor write: stops silently
    start_ch(1, 9);
    abort_req[1] = 1; desc_wr[1] = 1;
    tick();
    abort_req[1] = 0; desc_wr[1] = 0;
    strobe(1);
    check(chan_busy[1] == 0 && reg_rdata[5] == 0, "R5 silent stop", reg_rdata, 0);

    // R6 idle abort ignored
    abort_req = 2'b11;
    tick(); tick();
    abort_req = '0;
    check(chan_busy == 2'b00 && reg_rdata == 8'h00, "R6 idle abort ignored", reg_rdata, 0);

    // R12 start with length 0, then start while busy
    start_ch(0, 0);
    check(chan_busy[0] == 0, "R12 zero length ignored", chan_busy[0], 0);
    start_ch(0, 2);
    start_ch(0, 50);
    strobe(0); strobe(0);
    check(chan_busy[0] == 0, "R12 restart while busy ignored", chan_busy[0], 0);

    // R7 set and ack in the same cycle: set wins
    ctrl_write(8'h46);
    start_ch(1, 1);
    byte_done[1] = 1; reg_we = 1; reg_addr = 1; reg_wdata = 8'h66;
    tick();
    idle_inputs();
    check(reg_rdata == 8'h44, "R7 ack bits read zero", reg_rdata, 8'h44);
    reg_addr = 0; #1;
    check(reg_rdata[5] == 1, "R7 set wins over ack", reg_rdata, 8'h20);

    // R8 write to status has no effect
    reg_we = 1; reg_addr = 0; reg_wdata = 8'hFF;
    tick();
    reg_we = 0;
    check(reg_rdata == 8'h20, "R8 status write ignored", reg_rdata, 8'h20);
    ctrl_write(8'h00);
    reg_addr = 0; #1;
    check(reg_rdata[1] == 0, "R8 control write cannot set flag", reg_rdata, 8'h20);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < 2; c++) begin
        flow_start[c]    = ($urandom % 8) == 0;
        flow_len[c]      = LW'($urandom % 12);
        byte_done[c]     = ($urandom % 2) == 0;
        abort_req[c]     = ($urandom % 10) == 0;
        abort_delayed[c] = $urandom % 2;
        desc_wr[c]       = ($urandom % 5) == 0;
      end
      reg_we     = ($urandom % 7) == 0;
      reg_addr   = $urandom % 2;
      reg_wdata  = 8'($urandom);
      if (($urandom % 50) == 0) irq_glb_en = ~irq_glb_en;
      tick();
    end
    idle_inputs();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule